// File: doc/BRIEF.md
# Data Object Exchange Mailbox Engine

This block is the register-facing engine behind one PCIe Data Object Exchange capability. Host software loads a request into a write mailbox one dword at a time and then sets a go bit. The block passes the finished request to a protocol handler. The handler reads the request through an indexed port and streams response dwords back. It then reports either completion or rejection. Software pulls the response out of a read mailbox. A read returns the dword at the current index, and a write of any value to the same register advances that index.

Each instance owns exactly one mailbox pair. The set of protocols an instance understands lives entirely in the handler attached to it, so several instances may serve overlapping protocol sets without any coupling between them. The engine keeps the control and status bits and handles abort and reject clean-up. It also produces a one-cycle interrupt pulse on either an MSI-X or an MSI path, together with a fixed vector number.

Register map (dword offsets on `reg_addr`):
- offset 0, capability (read-only): bit 0 = interrupt capable, bits 11:1 = vector.
- offset 1, control: bit 0 = abort, bit 1 = interrupt enable, bit 31 = go.
- offset 2, status: bit 0 = busy, bit 1 = interrupt status, bit 2 = error, bit 31 = response ready.
- offset 3, write mailbox.
- offset 4, read mailbox.

Top module: `doe_mbox_engine`

## Requirements
- R1: After reset, status (offset 2) and control (offset 1) read 0, the read mailbox (offset 4) reads 0, no request or interrupt pulse is active, and capability (offset 0) reads bit 0 = IRQ_CAPABLE, bits 11:1 = IRQ_VECTOR.
- R2: Request dwords written to offset 3 are kept in order. Writing control with bit 31 set makes `hreq_valid` high for exactly one cycle after the write, with `hreq_len` equal to the dword count, and sets status bit 0 (busy). The handler reads dword i on `hreq_data` by driving `hreq_idx` = i.
- R3: A write-mailbox write when DEPTH dwords are already held is dropped and sets status bit 2 (error). A response push beyond DEPTH dwords does the same. Write-mailbox writes while busy are dropped.
- R4: An accepted completion clears busy, clears the request length, and sets status bit 31 when at least one response dword was pushed. Offset 4 then returns the response dwords in order, one per write to offset 4. Status bit 31 clears after the last dword has been consumed.
- R5: On an accepted completion, status bit 1 is set only if IRQ_CAPABLE is 1 and control bit 1 is set. Writing 1 to status bit 1 clears it, and writing 0 there leaves it unchanged.
- R6: When an interrupt is raised, `irq_msix` pulses for one cycle if `msix_en` is high. Otherwise `irq_msi` pulses if `msi_en` is high. Otherwise there is no pulse. The two pulses are never high together, and `irq_vector` equals IRQ_VECTOR.
- R7: Writing control with bit 0 set clears busy, error and response ready, zeroes the read buffer (offset 4 then reads 0), and clears the request length. A completion arriving after an abort is ignored.
- R8: A rejected completion sets error, leaves response ready clear, zeroes the read buffer, clears the request length, and raises no interrupt.
- R9: Go is ignored while busy, while error is set, or with an empty write mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register dword offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| hreq_valid | output | 1 | One-cycle request-ready pulse to the handler |
| hreq_len | output | LEN_W | Request length in dwords |
| hreq_idx | input | IDX_W | Handler read index into the request |
| hreq_data | output | 32 | Request dword at hreq_idx |
| hrsp_push | input | 1 | Handler appends one response dword |
| hrsp_data | input | 32 | Response dword |
| hrsp_done | input | 1 | Handler finished the exchange |
| hrsp_reject | input | 1 | With hrsp_done: request rejected |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| irq_msix | output | 1 | MSI-X interrupt pulse |
| irq_msi | output | 1 | MSI interrupt pulse |
| irq_vector | output | 11 | Interrupt vector number |

## Verification
The assertions take for granted that the handler drives `hrsp_push` and `hrsp_done` only while the engine is busy, never both in the same cycle, and only after it has seen `hreq_valid`. The bench plays the handler from tasks that respect this ordering: it reads the whole request, pushes the response dwords one per cycle, and then signals completion. Request and response lengths, interrupt enable, delivery-path selects and rejections are drawn at random from a fixed seed. Directed cases cover full-depth and overflow lengths, abort while busy, and a late completion.

// File: rtl/doe_mbox_pkg.sv
package doe_mbox_pkg;

    localparam int VEC_W = 11;

    typedef enum logic [2:0] {
        OFS_CAP    = 3'd0,
        OFS_CTRL   = 3'd1,
        OFS_STATUS = 3'd2,
        OFS_WMBOX  = 3'd3,
        OFS_RMBOX  = 3'd4
    } reg_ofs_e;

    localparam int CTL_ABORT = 0;
    localparam int CTL_IEN   = 1;
    localparam int CTL_GO    = 31;

    localparam int STS_BUSY  = 0;
    localparam int STS_INTR  = 1;
    localparam int STS_ERR   = 2;
    localparam int STS_READY = 31;

    typedef struct packed {
        logic ready;
        logic err;
        logic intr;
        logic busy;
    } mbox_status_t;

    function automatic logic [31:0] pack_status(mbox_status_t s);
        logic [31:0] w;
        w            = '0;
        w[STS_BUSY]  = s.busy;
        w[STS_INTR]  = s.intr;
        w[STS_ERR]   = s.err;
        w[STS_READY] = s.ready;
        return w;
    endfunction

    function automatic logic [31:0] pack_cap(logic capable, logic [VEC_W-1:0] vec);
        logic [31:0] w;
        w          = '0;
        w[0]       = capable;
        w[VEC_W:1] = vec;
        return w;
    endfunction

endpackage

// File: rtl/doe_req_buf.sv
module doe_req_buf #(
    parameter  int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic [LEN_W-1:0] len,
    output logic             full
);
    logic [31:0]      mem [DEPTH];
    logic [LEN_W-1:0] len_q;

    assign full    = (len_q == LEN_W'(DEPTH));
    assign len     = len_q;
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len_q <= '0;
        end else if (wr_en && !full) begin
            len_q <= len_q + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clr && wr_en && !full) begin
            mem[len_q[IDX_W-1:0]] <= wr_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !clr) |=> $stable(len_q)) else $error("write past depth changed length"); // R3

    AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (len_q == '0)) else $error("request length not cleared"); // R7
endmodule

// File: rtl/doe_rsp_buf.sv
module doe_rsp_buf #(
    parameter  int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             restart,
    input  logic             push,
    input  logic [31:0]      push_data,
    input  logic             pop,
    output logic [31:0]      rd_data,
    output logic [LEN_W-1:0] len,
    output logic             last,
    output logic             full
);
    logic [31:0]      mem [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;

    assign full    = (len_q == LEN_W'(DEPTH));
    assign len     = len_q;
    assign last    = ((LEN_W'(idx_q) + LEN_W'(1)) == len_q);
    assign rd_data = mem[idx_q];

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            idx_q <= '0;
            len_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (restart) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (push && !full) begin
            mem[len_q[IDX_W-1:0]] <= push_data;
            len_q                 <= len_q + LEN_W'(1);
        end else if (pop) begin
            if (last) begin
                idx_q <= '0;
                len_q <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (len_q == '0 && rd_data == '0)) else $error("read buffer not zeroed"); // R8
endmodule

// File: rtl/doe_irq_gen.sv
module doe_irq_gen #(
    parameter bit IRQ_CAPABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ien,
    input  logic raise,
    input  logic sts_w1c,
    input  logic msix_en,
    input  logic msi_en,
    output logic intr_sts,
    output logic msix_pulse,
    output logic msi_pulse
);
    logic fire;
    assign fire = IRQ_CAPABLE && ien && raise;

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_sts   <= 1'b0;
            msix_pulse <= 1'b0;
            msi_pulse  <= 1'b0;
        end else begin
            msix_pulse <= fire && msix_en;
            msi_pulse  <= fire && !msix_en && msi_en;
            if (fire) begin
                intr_sts <= 1'b1;
            end else if (sts_w1c) begin
                intr_sts <= 1'b0;
            end
        end
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (raise && !(IRQ_CAPABLE && ien)) |=> (!msix_pulse && !msi_pulse)) else $error("interrupt without enable"); // R5

    AST_IRQ_STATUS: assert property (@(posedge clk) disable iff (rst)
        (raise && IRQ_CAPABLE && ien) |=> intr_sts) else $error("interrupt raised without status"); // R5

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
        !(msix_pulse && msi_pulse)) else $error("both delivery paths fired"); // R6
endmodule

// File: rtl/doe_mbox_engine.sv
module doe_mbox_engine
    import doe_mbox_pkg::*;
#(
    parameter  int               DEPTH       = 16,
    parameter  bit               IRQ_CAPABLE = 1'b1,
    parameter  logic [VEC_W-1:0] IRQ_VECTOR  = 11'd5,
    localparam int               LEN_W       = $clog2(DEPTH + 1),
    localparam int               IDX_W       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             hreq_valid,
    output logic [LEN_W-1:0] hreq_len,
    input  logic [IDX_W-1:0] hreq_idx,
    output logic [31:0]      hreq_data,
    input  logic             hrsp_push,
    input  logic [31:0]      hrsp_data,
    input  logic             hrsp_done,
    input  logic             hrsp_reject,
    input  logic             msix_en,
    input  logic             msi_en,
    output logic             irq_msix,
    output logic             irq_msi,
    output logic [VEC_W-1:0] irq_vector
);
    logic busy_q, err_q, ready_q, ien_q, hreq_q;
    logic wr_ctrl, abort, go_ok, wr_mbox, req_ovf, rsp_ovf;
    logic done_ok, done_rej, pop, mbox_clr, rsp_push, sts_w1c;
    logic [LEN_W-1:0] req_len, rsp_len;
    logic req_full, rsp_full, rsp_last, intr_sts;
    logic [31:0] rsp_rd_data;
    mbox_status_t sts;

    // Register write decode
    assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    assign abort    = wr_ctrl && reg_wdata[CTL_ABORT];
    assign go_ok    = wr_ctrl && reg_wdata[CTL_GO] && !reg_wdata[CTL_ABORT]
                      && !busy_q && !err_q && (req_len != '0);
    assign wr_mbox  = reg_wr && (reg_addr == OFS_WMBOX) && !busy_q;
    assign req_ovf  = wr_mbox && req_full;
    assign pop      = reg_wr && (reg_addr == OFS_RMBOX) && ready_q;
    assign sts_w1c  = reg_wr && (reg_addr == OFS_STATUS) && reg_wdata[STS_INTR];

    // Handler side
    assign rsp_push = hrsp_push && busy_q;
    assign rsp_ovf  = rsp_push && rsp_full;
    assign done_ok  = hrsp_done && busy_q && !hrsp_reject && !abort;
    assign done_rej = hrsp_done && busy_q && hrsp_reject;
    assign mbox_clr = abort || done_rej;

    doe_req_buf #(.DEPTH(DEPTH)) u_req (
        .clk     (clk),
        .rst     (rst),
        .clr     (mbox_clr || done_ok),
        .wr_en   (wr_mbox),
        .wr_data (reg_wdata),
        .rd_idx  (hreq_idx),
        .rd_data (hreq_data),
        .len     (req_len),
        .full    (req_full)
    );

    doe_rsp_buf #(.DEPTH(DEPTH)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (mbox_clr),
        .restart   (go_ok),
        .push      (rsp_push),
        .push_data (hrsp_data),
        .pop       (pop),
        .rd_data   (rsp_rd_data),
        .len       (rsp_len),
        .last      (rsp_last),
        .full      (rsp_full)
    );

    doe_irq_gen #(.IRQ_CAPABLE(IRQ_CAPABLE)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .ien        (ien_q),
        .raise      (done_ok),
        .sts_w1c    (sts_w1c),
        .msix_en    (msix_en),
        .msi_en     (msi_en),
        .intr_sts   (intr_sts),
        .msix_pulse (irq_msix),
        .msi_pulse  (irq_msi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            ready_q <= 1'b0;
            ien_q   <= 1'b0;
            hreq_q  <= 1'b0;
        end else begin
            hreq_q <= go_ok;
            if (wr_ctrl) begin
                ien_q <= reg_wdata[CTL_IEN];
            end
            if (abort) begin
                busy_q  <= 1'b0;
                err_q   <= 1'b0;
                ready_q <= 1'b0;
            end else begin
                if (go_ok) begin
                    busy_q  <= 1'b1;
                    ready_q <= 1'b0;
                end
                if (done_ok) begin
                    busy_q  <= 1'b0;
                    ready_q <= (rsp_len != '0);
                end
                if (done_rej) begin
                    busy_q  <= 1'b0;
                    err_q   <= 1'b1;
                    ready_q <= 1'b0;
                end
                if (req_ovf || rsp_ovf) begin
                    err_q <= 1'b1;
                end
                if (pop && rsp_last) begin
                    ready_q <= 1'b0;
                end
            end
        end
    end

    assign sts = '{ready: ready_q, err: err_q, intr: intr_sts, busy: busy_q};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CAP:    reg_rdata = pack_cap(IRQ_CAPABLE, IRQ_VECTOR);
            OFS_CTRL:   reg_rdata[CTL_IEN] = ien_q;
            OFS_STATUS: reg_rdata = pack_status(sts);
            OFS_RMBOX:  reg_rdata = rsp_rd_data;
            default:    reg_rdata = '0;
        endcase
    end

    assign hreq_valid = hreq_q;
    assign hreq_len   = req_len;
    assign irq_vector = IRQ_VECTOR;

    AST_HREQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        hreq_q |-> busy_q) else $error("request pulse while idle"); // R2

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy_q && !err_q && !ready_q)) else $error("abort left state"); // R7

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (done_rej && !abort) |=> (err_q && !ready_q && !busy_q)) else $error("reject not flagged"); // R8

    AST_GO_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reg_wdata[CTL_GO] && (busy_q || err_q)) |=> !hreq_q) else $error("go accepted while blocked"); // R9
endmodule

// File: tb/test_doe_mbox_engine.sv
module test_doe_mbox_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LEN_W      = $clog2(DEPTH + 1);
    localparam int IDX_W      = $clog2(DEPTH);
    localparam logic [10:0] VEC = 11'd5;

    localparam logic [2:0] A_CAP = 3'd0, A_CTRL = 3'd1, A_STS = 3'd2, A_WMB = 3'd3, A_RMB = 3'd4;
    localparam logic [31:0] C_ABORT = 32'h1, C_IEN = 32'h2, C_GO = 32'h8000_0000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst, reg_wr, hrsp_push, hrsp_done, hrsp_reject, msix_en, msi_en;
    logic [2:0] reg_addr;
    logic [31:0] reg_wdata, hrsp_data;
    logic [IDX_W-1:0] hreq_idx;
    logic [31:0] reg_rdata, hreq_data, n_rdata, n_hreq_data;
    logic hreq_valid, irq_msix, irq_msi, n_hreq_valid, n_msix, n_msi;
    logic [LEN_W-1:0] hreq_len, n_hreq_len;
    logic [10:0] irq_vector, n_vector;

    doe_mbox_engine #(.DEPTH(DEPTH), .IRQ_CAPABLE(1'b1), .IRQ_VECTOR(VEC)) i_doe_mbox_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hreq_valid(hreq_valid), .hreq_len(hreq_len), .hreq_idx(hreq_idx),
        .hreq_data(hreq_data), .hrsp_push(hrsp_push), .hrsp_data(hrsp_data), .hrsp_done(hrsp_done),
        .hrsp_reject(hrsp_reject), .msix_en(msix_en), .msi_en(msi_en), .irq_msix(irq_msix),
        .irq_msi(irq_msi), .irq_vector(irq_vector));

    doe_mbox_engine #(.DEPTH(DEPTH), .IRQ_CAPABLE(1'b0), .IRQ_VECTOR(VEC)) i_nocap (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(n_rdata), .hreq_valid(n_hreq_valid), .hreq_len(n_hreq_len), .hreq_idx(hreq_idx),
        .hreq_data(n_hreq_data), .hrsp_push(hrsp_push), .hrsp_data(hrsp_data), .hrsp_done(hrsp_done),
        .hrsp_reject(hrsp_reject), .msix_en(msix_en), .msi_en(msi_en), .irq_msix(n_msix),
        .irq_msi(n_msi), .irq_vector(n_vector));

    int n_chk = 0;
    int n_bad = 0;
    bit exp_intr = 1'b0;
    logic [31:0] req_w [DEPTH];
    logic [31:0] rsp_w [DEPTH];

    function automatic logic [31:0] exp_sts(bit busy, bit intr, bit err, bit ready);
        return {ready, 28'd0, err, intr, busy};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(logic [31:0] d);
        @(negedge clk);
        hrsp_push = 1'b1; hrsp_data = d;
        @(negedge clk);
        hrsp_push = 1'b0;
    endtask

    task automatic done(bit rej);
        @(negedge clk);
        hrsp_done = 1'b1; hrsp_reject = rej;
        @(negedge clk);
        hrsp_done = 1'b0; hrsp_reject = 1'b0;
    endtask

    task automatic exchange(int nq, int nr, bit ien, bit mx, bit ms, bit rej);
        logic [31:0] v;
        bit fire;
        logic [31:0] ien_w;
        ien_w = ien ? C_IEN : 32'h0;
        msix_en = mx; msi_en = ms;
        for (int i = 0; i < nq; i++) begin
            req_w[i] = $urandom;
            wr(A_WMB, req_w[i]);
        end
        wr(A_CTRL, C_GO | ien_w);
        chk("R2", "request pulse", 32'(hreq_valid), 32'd1);
        chk("R2", "request length", 32'(hreq_len), 32'(nq));
        rd(A_STS, v);
        chk("R2", "busy after go", v, exp_sts(1, exp_intr, 0, 0));
        chk("R2", "request pulse is one cycle", 32'(hreq_valid), 32'd0);
        for (int i = 0; i < nq; i++) begin
            @(negedge clk);
            hreq_idx = IDX_W'(i);
            #1;
            chk("R2", "request dword", hreq_data, req_w[i]);
        end
        for (int i = 0; i < nr; i++) begin
            rsp_w[i] = $urandom | 32'h1;
            push(rsp_w[i]);
        end
        done(rej);
        fire = !rej && ien;
        chk("R6", "msix pulse", 32'(irq_msix), 32'(fire && mx));
        chk("R6", "msi pulse", 32'(irq_msi), 32'(fire && !mx && ms));
        chk("R5", "no pulse without capability", {30'd0, n_msix, n_msi}, 32'd0);
        if (fire) exp_intr = 1'b1;
        if (rej) begin
            chk("R8", "no pulse on reject", {30'd0, irq_msix, irq_msi}, 32'd0);
            rd(A_STS, v);
            chk("R8", "status after reject", v, exp_sts(0, exp_intr, 1, 0));
            rd(A_RMB, v);
            chk("R8", "read buffer zeroed", v, 32'd0);
            chk("R8", "request length cleared", 32'(hreq_len), 32'd0);
            wr(A_CTRL, C_ABORT | ien_w);
            rd(A_STS, v);
            chk("R7", "abort clears error", v, exp_sts(0, exp_intr, 0, 0));
        end else begin
            rd(A_STS, v);
            chk("R4", "status after completion", v, exp_sts(0, exp_intr, 0, nr > 0));
            chk("R5", "no-capability status", n_rdata & 32'h2, 32'd0);
            chk("R4", "request length cleared", 32'(hreq_len), 32'd0);
            for (int i = 0; i < nr; i++) begin
                rd(A_RMB, v);
                chk("R4", "response dword", v, rsp_w[i]);
                rd(A_STS, v);
                chk("R4", "ready while unread", v & 32'h8000_0000, 32'h8000_0000);
                wr(A_RMB, $urandom);
            end
            rd(A_STS, v);
            chk("R4", "ready clears after last", v, exp_sts(0, exp_intr, 0, 0));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_0d0e));
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; hreq_idx = '0;
        hrsp_push = 1'b0; hrsp_data = '0; hrsp_done = 1'b0; hrsp_reject = 1'b0;
        msix_en = 1'b0; msi_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CAP, v);
        chk("R1", "capability", v, 32'h0000_000B);
        chk("R1", "capability without irq", n_rdata, 32'h0000_000A);
        rd(A_CTRL, v);   chk("R1", "control", v, 32'd0);
        rd(A_STS, v);    chk("R1", "status", v, 32'd0);
        rd(A_RMB, v);    chk("R1", "read mailbox", v, 32'd0);
        chk("R1", "idle outputs", {29'd0, hreq_valid, irq_msix, irq_msi}, 32'd0);
        chk("R6", "vector", 32'(irq_vector), 32'(VEC));

        // R9 go with empty mailbox
        wr(A_CTRL, C_GO);
        chk("R9", "go on empty mailbox", 32'(hreq_valid), 32'd0);
        rd(A_STS, v);    chk("R9", "still idle", v, 32'd0);

        // R3 request overflow, R9 go blocked by error, R7 abort
        for (int i = 0; i <= DEPTH; i++) wr(A_WMB, 32'(i));
        rd(A_STS, v);    chk("R3", "overflow sets error", v, exp_sts(0, 0, 1, 0));
        chk("R3", "length capped", 32'(hreq_len), 32'(DEPTH));
        wr(A_CTRL, C_GO);
        chk("R9", "go blocked by error", 32'(hreq_valid), 32'd0);
        wr(A_CTRL, C_ABORT);
        rd(A_STS, v);    chk("R7", "abort clears error", v, 32'd0);
        chk("R7", "abort clears length", 32'(hreq_len), 32'd0);

        // R3 write while busy dropped, R9 go while busy
        wr(A_WMB, 32'hA1); wr(A_WMB, 32'hA2);
        wr(A_CTRL, C_GO);
        wr(A_WMB, 32'hA3);
        chk("R3", "write while busy dropped", 32'(hreq_len), 32'd2);
        wr(A_CTRL, C_GO);
        chk("R9", "go while busy", 32'(hreq_valid), 32'd0);
        done(1'b0);
        rd(A_STS, v);    chk("R4", "empty response not ready", v, 32'd0);

        // R7 abort while busy, late completion ignored
        wr(A_WMB, 32'hB1);
        wr(A_CTRL, C_GO);
        wr(A_CTRL, C_ABORT);
        rd(A_STS, v);    chk("R7", "abort while busy", v, 32'd0);
        push(32'hDEAD);
        done(1'b0);
        rd(A_STS, v);    chk("R7", "late completion ignored", v, 32'd0);
        rd(A_RMB, v);    chk("R7", "late push ignored", v, 32'd0);

        // R3 response overflow
        wr(A_WMB, 32'hC1);
        wr(A_CTRL, C_GO);
        for (int i = 0; i <= DEPTH; i++) push(32'h100 + 32'(i));
        done(1'b0);
        rd(A_STS, v);    chk("R3", "response overflow", v, exp_sts(0, 0, 1, 1));
        rd(A_RMB, v);    chk("R3", "first response kept", v, 32'h100);
        wr(A_CTRL, C_ABORT);
        rd(A_RMB, v);    chk("R7", "abort zeroes read buffer", v, 32'd0);
        rd(A_STS, v);    chk("R7", "abort clears ready", v, 32'd0);

        // R5 / R6 delivery paths and interrupt status
        exchange(3, 3, 1, 1, 1, 0);
        wr(A_STS, 32'h0);
        rd(A_STS, v);    chk("R5", "write 0 keeps intr", v, exp_sts(0, 1, 0, 0));
        wr(A_STS, 32'h2); exp_intr = 1'b0;
        rd(A_STS, v);    chk("R5", "write 1 clears intr", v, 32'd0);
        exchange(2, 2, 1, 0, 1, 0);
        wr(A_STS, 32'h2); exp_intr = 1'b0;
        exchange(1, 2, 1, 0, 0, 0);
        rd(A_STS, v);    chk("R5", "intr set with no path", v, exp_sts(0, 1, 0, 0));
        wr(A_STS, 32'h2); exp_intr = 1'b0;
        exchange(2, 2, 0, 1, 1, 0);
        rd(A_STS, v);    chk("R5", "no intr when disabled", v, 32'd0);

        // R8 reject after a response left data in the buffer
        exchange(2, 3, 0, 0, 0, 0);
        exchange(2, 2, 1, 1, 0, 1);

        // full depth both ways
        exchange(DEPTH, DEPTH, 1, 1, 0, 0);
        wr(A_STS, 32'h2); exp_intr = 1'b0;

        // random exchanges
        for (int k = 0; k < 40; k++) begin
            exchange(1 + int'($urandom % DEPTH), 1 + int'($urandom % DEPTH),
                     bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                     ($urandom % 5) == 0);
            if ($urandom % 2) begin
                wr(A_STS, 32'h2);
                exp_intr = 1'b0;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule